// File: doc/BRIEF.md
# Delay-Line Phase Search Controller

This block picks a coarse and a fine delay code for a clock delay line, so that a measured clock phase lands on a programmable target value and the phase detector's slope at that point has the wanted sign. A start pulse loads both codes from programmed initial values. The controller then sweeps the coarse code upward, one step for each accepted measurement, until a measurement equals the target or the measurement passes from one side of the target to the other. At that coarse code it probes the fine code one step below and one step above its home value, which gives the slope sign. If the sign is the wanted one, the controller locks and tracks. If it is not, the fine code goes back to its home value and the coarse sweep resumes at the next coarse code.

In tracking, each accepted measurement that lies outside a programmable tolerance band around the target moves the fine code by one step, in the direction that brings the phase back toward the target. Both directions saturate at the ends of the fine range. If the coarse code reaches its top value without a lock, the controller raises an error flag and parks in idle until the next start. The delay cells and the phase detector are not part of the block. The phase detector appears only as a sampled measurement with a valid strobe, and the block acts on a measurement only in a cycle where the strobe is high.

States and transitions:

| State | Code | Transitions |
|---|---|---|
| IDLE | 0 | start → SEEK |
| SEEK | 1 | hit → SLOPE_LO; miss below the coarse top → SEEK; miss at the coarse top → IDLE with the error flag set |
| SLOPE_LO | 2 | measurement → SLOPE_HI |
| SLOPE_HI | 3 | slope match → TRACK; mismatch below the coarse top → SEEK; mismatch at the coarse top → IDLE with the error flag set |
| TRACK | 4 | stays in TRACK until the next start |

A start pulse moves every state to SEEK.

Top module: `dlyline_seek`

## Requirements
- R1: A start pulse, in any state, loads coarse_o from init_coarse_i and fine_o from init_fine_i, clears err_o and enters SEEK (state code 1) on the next clock edge. Start takes priority over any measurement in the same cycle.
- R2: In a cycle where meas_vld_i is low and start_i is low, coarse_o and fine_o keep their values and the state does not change.
- R3: In SEEK, a valid measurement equal to target_i is a hit. On a hit, the current fine code is saved as the home code and fine_o becomes home minus one (held at 0), with the state moving to SLOPE_LO (code 2). The next valid measurement sets fine_o to home plus one (held at the fine maximum), with the state moving to SLOPE_HI (code 3).
- R4: In SEEK, a valid measurement is also a hit when the previous SEEK measurement since start was on the other side of target_i. Below means less than the target, and equal counts as not below.
- R5: In SEEK, a valid measurement that is not a hit, taken while coarse_o is below its maximum, increments coarse_o by one and keeps the fine code.
- R6: The slope counts as rising when the measurement at home plus one is greater than the one at home minus one, and as falling when it is smaller. Equal counts as a mismatch. want_rising_i = 1 asks for rising and 0 asks for falling.
- R7: On a slope match, fine_o returns to the home code, coarse_o is kept, and the state becomes TRACK (code 4) with locked_o = 1.
- R8: On a slope mismatch while coarse_o is below its maximum, fine_o returns to the home code, coarse_o increments by one, and the state returns to SEEK.
- R9: A miss in SEEK, or a slope mismatch, while coarse_o is at its maximum sets err_o = 1 and enters IDLE (code 0). The coarse code is kept, and the fine code ends at its home value.
- R10: A hit, whether an equality or a crossing, while coarse_o is at its maximum goes to the slope step and not to the error.
- R11: In TRACK, a valid measurement above target_i + tol_i moves fine_o one step in the direction that lowers the phase (down for a rising slope, up for a falling one). A measurement below target_i - tol_i moves it the other way. A measurement inside the band leaves it unchanged.
- R12: The fine code saturates at 0 and at its maximum, both in the slope probe and in tracking.
- R13: After reset, state_o = 0, coarse_o = 0, fine_o = 0, locked_o = 0 and err_o = 0. locked_o is 1 exactly while the state is TRACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or restart the search |
| init_coarse_i | input | CW | Coarse code loaded on start |
| init_fine_i | input | FW | Fine code loaded on start |
| target_i | input | PW | Target phase value |
| want_rising_i | input | 1 | Wanted slope: 1 = rising, 0 = falling |
| tol_i | input | PW | Tracking tolerance band half-width |
| meas_i | input | PW | Phase-detector measurement for the current codes |
| meas_vld_i | input | 1 | Measurement valid strobe |
| coarse_o | output | CW | Coarse delay code |
| fine_o | output | FW | Fine delay code |
| state_o | output | 3 | State code (0 idle, 1 seek, 2 slope low, 3 slope high, 4 track) |
| locked_o | output | 1 | Tracking mode active |
| err_o | output | 1 | Coarse range used up without lock |

## Verification
The hit detection and the coarse-range limit test can act in the same cycle. A hit found while the coarse code is at its top value must go on to the slope probe, and only a miss or a slope mismatch there may raise the error. The bench provokes this collision by placing both an exact crossing and a wrong-slope hit on the top coarse code. It judges the outcome from the final lock state, the error flag, and the codes left at the ports. A second collision, a start pulse in a cycle with a valid measurement, is covered by restarting every scenario while measurements keep arriving. The codes must then equal the programmed initial values.

// File: rtl/dls_pkg.sv
package dls_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SEEK     = 3'd1,
        ST_SLOPE_LO = 3'd2,
        ST_SLOPE_HI = 3'd3,
        ST_TRACK    = 3'd4
    } dls_state_e;

endpackage

// File: rtl/dls_phase_cmp.sv
// Compares a phase measurement with the target and with the tolerance band.
module dls_phase_cmp #(
    parameter int PW = 8
) (
    input  logic [PW-1:0] meas_i,
    input  logic [PW-1:0] target_i,
    input  logic [PW-1:0] tol_i,
    output logic          eq_o,
    output logic          below_o,
    output logic          over_o,
    output logic          under_o
);
    localparam int XW = PW + 2;

    logic [XW-1:0] m_x;
    logic [XW-1:0] t_x;
    logic [XW-1:0] b_x;

    assign m_x     = XW'(meas_i);
    assign t_x     = XW'(target_i);
    assign b_x     = XW'(tol_i);

    assign eq_o    = (m_x == t_x);
    assign below_o = (m_x < t_x);
    assign over_o  = (m_x > t_x + b_x);
    assign under_o = (m_x + b_x < t_x);

endmodule

// File: rtl/dls_slope_eval.sv
// Holds the low-side probe sample and judges the slope against the current sample.
module dls_slope_eval #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic [PW-1:0] meas_i,
    output logic          rising_o,
    output logic          falling_o
);
    logic [PW-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (capture_i) begin
            lo_q <= meas_i;
        end
    end

    assign rising_o  = (meas_i > lo_q);
    assign falling_o = (meas_i < lo_q);

endmodule

// File: rtl/dls_sat_step.sv
// One-step increment and decrement of a code, held at the range ends.
module dls_sat_step #(
    parameter int W = 4
) (
    input  logic [W-1:0] code_i,
    output logic [W-1:0] inc_o,
    output logic [W-1:0] dec_o
);
    localparam logic [W-1:0] TOP = '1;

    assign inc_o = (code_i == TOP) ? code_i : code_i + 1'b1;
    assign dec_o = (code_i == '0)  ? code_i : code_i - 1'b1;

endmodule

// File: rtl/dlyline_seek.sv
module dlyline_seek
    import dls_pkg::*;
#(
    parameter int CW = 4,
    parameter int FW = 4,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] init_coarse_i,
    input  logic [FW-1:0] init_fine_i,
    input  logic [PW-1:0] target_i,
    input  logic          want_rising_i,
    input  logic [PW-1:0] tol_i,
    input  logic [PW-1:0] meas_i,
    input  logic          meas_vld_i,
    output logic [CW-1:0] coarse_o,
    output logic [FW-1:0] fine_o,
    output logic [2:0]    state_o,
    output logic          locked_o,
    output logic          err_o
);
    localparam logic [CW-1:0] COARSE_TOP = '1;

    dls_state_e    state_q, state_d;
    logic [CW-1:0] coarse_q;
    logic [FW-1:0] fine_q, home_q;
    logic          have_prev_q, prev_below_q, err_q;

    logic eq, below, over, under, rising, falling;
    logic [FW-1:0] fine_inc, fine_dec, home_inc, home_dec;
    logic hit, slope_ok, coarse_last, cap_lo;

    dls_phase_cmp #(.PW(PW)) u_cmp (
        .meas_i   (meas_i),
        .target_i (target_i),
        .tol_i    (tol_i),
        .eq_o     (eq),
        .below_o  (below),
        .over_o   (over),
        .under_o  (under)
    );

    assign cap_lo = (state_q == ST_SLOPE_LO) && meas_vld_i;

    dls_slope_eval #(.PW(PW)) u_slope (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (cap_lo),
        .meas_i    (meas_i),
        .rising_o  (rising),
        .falling_o (falling)
    );

    dls_sat_step #(.W(FW)) u_fine_step (
        .code_i (fine_q),
        .inc_o  (fine_inc),
        .dec_o  (fine_dec)
    );

    dls_sat_step #(.W(FW)) u_home_step (
        .code_i (home_q),
        .inc_o  (home_inc),
        .dec_o  (home_dec)
    );

    assign hit         = eq || (have_prev_q && (below != prev_below_q));
    assign slope_ok    = want_rising_i ? rising : falling;
    assign coarse_last = (coarse_q == COARSE_TOP);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_SEEK;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_SEEK: begin
                    if (meas_vld_i) begin
                        if (hit)              state_d = ST_SLOPE_LO;
                        else if (coarse_last) state_d = ST_IDLE;
                    end
                end
                ST_SLOPE_LO: if (meas_vld_i) state_d = ST_SLOPE_HI;
                ST_SLOPE_HI: begin
                    if (meas_vld_i) begin
                        if (slope_ok)         state_d = ST_TRACK;
                        else if (coarse_last) state_d = ST_IDLE;
                        else                  state_d = ST_SEEK;
                    end
                end
                ST_TRACK:    state_d = ST_TRACK;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Codes and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coarse_q     <= '0;
            fine_q       <= '0;
            home_q       <= '0;
            have_prev_q  <= 1'b0;
            prev_below_q <= 1'b0;
            err_q        <= 1'b0;
        end else if (start_i) begin
            coarse_q     <= init_coarse_i;
            fine_q       <= init_fine_i;
            home_q       <= init_fine_i;
            have_prev_q  <= 1'b0;
            prev_below_q <= 1'b0;
            err_q        <= 1'b0;
        end else if (meas_vld_i) begin
            unique case (state_q)
                ST_SEEK: begin
                    have_prev_q  <= 1'b1;
                    prev_below_q <= below;
                    if (hit) begin
                        home_q <= fine_q;
                        fine_q <= fine_dec;
                    end else if (coarse_last) begin
                        err_q <= 1'b1;
                    end else begin
                        coarse_q <= coarse_q + 1'b1;
                    end
                end
                ST_SLOPE_LO: fine_q <= home_inc;
                ST_SLOPE_HI: begin
                    fine_q <= home_q;
                    if (!slope_ok) begin
                        if (coarse_last) err_q <= 1'b1;
                        else             coarse_q <= coarse_q + 1'b1;
                    end
                end
                ST_TRACK: begin
                    if (over)       fine_q <= want_rising_i ? fine_dec : fine_inc;
                    else if (under) fine_q <= want_rising_i ? fine_inc : fine_dec;
                end
                default: ;
            endcase
        end
    end

    assign coarse_o = coarse_q;
    assign fine_o   = fine_q;
    assign state_o  = state_q;
    assign locked_o = (state_q == ST_TRACK);
    assign err_o    = err_q;

    // R1
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (coarse_q == $past(init_coarse_i)) && (fine_q == $past(init_fine_i))
                    && (state_q == ST_SEEK) && !err_q);

    // R2
    hold_wo_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !meas_vld_i) |=> $stable(coarse_q) && $stable(fine_q));

    // R5
    coarse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i) |=> ($stable(coarse_q) || (coarse_q == CW'($past(coarse_q) + 1'b1))));

    // R7
    fine_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLOPE_HI && meas_vld_i && !start_i) |=> (fine_q == $past(home_q)));

    // R9
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (state_q == ST_IDLE));

    // R11
    track_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACK && !start_i) |=>
            ($stable(fine_q) || (fine_q == FW'($past(fine_q) + 1'b1))
             || (fine_q == FW'($past(fine_q) - 1'b1))));

endmodule

// File: tb/test_dlyline_seek.sv
module test_dlyline_seek;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] init_c = '0;
    logic [3:0] init_f = '0;
    logic [7:0] target = '0;
    logic       want_r = 1'b1;
    logic [7:0] tol = 8'd2;
    logic [7:0] meas;
    logic       vld = 1'b1;
    logic [3:0] coarse;
    logic [3:0] fine;
    logic [2:0] state;
    logic       locked;
    logic       err;

    int checks = 0;
    int errors = 0;
    int ctab[16];
    int gtab[16];
    int v;

    always #5 clk = ~clk;

    // Phase detector model: per-coarse base plus a per-coarse fine gain around fine 8
    always_comb begin
        v = ctab[coarse] + gtab[coarse] * (int'(fine) - 8);
        if (v < 0)   v = 0;
        if (v > 255) v = 255;
        meas = 8'(v);
    end

    dlyline_seek i_dlyline_seek (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .init_coarse_i (init_c),
        .init_fine_i   (init_f),
        .target_i      (target),
        .want_rising_i (want_r),
        .tol_i         (tol),
        .meas_i        (meas),
        .meas_vld_i    (vld),
        .coarse_o      (coarse),
        .fine_o        (fine),
        .state_o       (state),
        .locked_o      (locked),
        .err_o         (err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill(input int base, input int gain);
        for (int i = 0; i < 16; i++) begin
            ctab[i] = base;
            gtab[i] = gain;
        end
    endtask

    task automatic do_start(input int c, input int f);
        @(negedge clk);
        init_c = 4'(c);
        init_f = 4'(f);
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 100; i++) begin
            if (state == 3'd4 || err) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R13 reset state", state, 0);
        chk("R13 reset coarse", coarse, 0);
        chk("R13 reset fine", fine, 0);
        chk("R13 reset locked", locked, 0);
        chk("R13 reset err", err, 0);
    endtask

    task automatic t_no_valid();
        fill(0, 1);
        target = 8'd200;
        vld = 1'b0;
        do_start(6, 3);
        chk("R1 seek entered", state, 1);
        repeat (5) @(negedge clk);
        chk("R2 coarse held", coarse, 6);
        chk("R2 fine held", fine, 3);
        chk("R2 state held", state, 1);
        vld = 1'b1;
    endtask

    task automatic t_exact();
        fill(0, 1);
        for (int i = 0; i < 16; i++) ctab[i] = 10 * i + 8;
        target = 8'd48;
        want_r = 1'b1;
        do_start(2, 8);
        wait_end();
        chk("R3 exact hit coarse", coarse, 4);
        chk("R7 fine home", fine, 8);
        chk("R7 track state", state, 4);
        chk("R13 locked in track", locked, 1);
    endtask

    task automatic t_cross();
        fill(0, 1);
        for (int i = 0; i < 16; i++) ctab[i] = 10 * i;
        target = 8'd35;
        want_r = 1'b1;
        do_start(1, 8);
        wait_end();
        chk("R4 crossing coarse", coarse, 4);
        chk("R4 crossing locked", locked, 1);
        fill(0, -1);
        for (int i = 0; i < 16; i++) ctab[i] = 200 - 10 * i;
        target = 8'd155;
        want_r = 1'b0;
        do_start(0, 8);
        wait_end();
        chk("R4 downward crossing coarse", coarse, 5);
        chk("R6 falling slope lock", locked, 1);
    endtask

    task automatic t_mismatch();
        fill(90, 1);
        ctab[0] = 0;  ctab[1] = 20; ctab[2] = 50; ctab[3] = 70; ctab[4] = 50;
        gtab[2] = -1; gtab[4] = 1;
        target = 8'd50;
        want_r = 1'b1;
        do_start(0, 8);
        wait_end();
        chk("R8 resumed sweep coarse", coarse, 4);
        chk("R8 fine restored", fine, 8);
        chk("R7 lock after mismatch", state, 4);
        fill(50, 0);
        do_start(3, 8);
        wait_end();
        chk("R6 flat slope never locks", locked, 0);
        chk("R9 flat slope error", err, 1);
    endtask

    task automatic t_wrap();
        fill(0, 1);
        target = 8'd200;
        do_start(10, 5);
        wait_end();
        chk("R9 err flag", err, 1);
        chk("R9 idle state", state, 0);
        chk("R9 coarse at top", coarse, 15);
        chk("R5 fine kept in sweep", fine, 5);
        chk("R13 not locked", locked, 0);
        do_start(10, 5);
        chk("R1 err cleared", err, 0);
    endtask

    task automatic t_top_collide();
        fill(0, 1);
        ctab[14] = 40; ctab[15] = 60;
        target = 8'd50;
        want_r = 1'b1;
        do_start(14, 8);
        wait_end();
        chk("R10 crossing at top locks", locked, 1);
        chk("R10 crossing at top coarse", coarse, 15);
        chk("R10 no error", err, 0);
        fill(0, -1);
        ctab[15] = 50;
        do_start(15, 8);
        wait_end();
        chk("R9 mismatch at top err", err, 1);
        chk("R9 mismatch at top fine home", fine, 8);
        chk("R9 mismatch at top idle", state, 0);
    endtask

    task automatic t_slope_sat();
        fill(50, 1);
        target = 8'd42;
        want_r = 1'b1;
        do_start(3, 0);
        wait_end();
        chk("R12 probe at fine 0 locks", locked, 1);
        chk("R12 fine 0 kept", fine, 0);
        target = 8'd57;
        do_start(3, 15);
        wait_end();
        chk("R12 probe at fine max locks", locked, 1);
        chk("R12 fine max kept", fine, 15);
    endtask

    task automatic t_track();
        fill(0, 1);
        ctab[5] = 50;
        target = 8'd50;
        tol = 8'd2;
        want_r = 1'b1;
        do_start(5, 8);
        wait_end();
        chk("R7 track lock", locked, 1);
        ctab[5] = 55;
        repeat (20) @(negedge clk);
        chk("R11 rising nudge down", fine, 5);
        ctab[5] = 44;
        repeat (20) @(negedge clk);
        chk("R11 rising nudge up", fine, 12);
        ctab[5] = 200;
        repeat (30) @(negedge clk);
        chk("R12 track low saturation", fine, 0);
        ctab[5] = -100;
        repeat (30) @(negedge clk);
        chk("R12 track high saturation", fine, 15);
        fill(0, -1);
        ctab[5] = 50;
        want_r = 1'b0;
        do_start(5, 8);
        wait_end();
        chk("R6 falling lock", locked, 1);
        ctab[5] = 55;
        repeat (20) @(negedge clk);
        chk("R11 falling nudge up", fine, 11);
        chk("R11 coarse held in track", coarse, 5);
    endtask

    initial begin
        fill(0, 1);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_no_valid();
        t_exact();
        t_cross();
        t_mismatch();
        t_wrap();
        t_top_collide();
        t_slope_sat();
        t_track();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule